// File: doc/BRIEF.md
# Memory-Mapped Reset Line Controller

The controller drives a wide vector of peripheral reset lines from a small 32-bit register port. Each line can be controlled in two ways. Software can fire a self-timed reset pulse by writing a one to the line's bit in a pulse register. Software can also hold the line in reset through a persistent, readable level register. The level registers are active low, so a cleared bit keeps the line in reset.

A line is asserted whenever its pulse timer is running or its level bit is zero. The output is taken from a flop, so it cannot glitch. Zero bits in a pulse write leave their lines alone, so one line can be pulsed without a prior read. The level registers read back their current contents, so software can change a single line with a read-modify-write.

Top module: `rst_line_ctrl`

## Requirements
- R1: After `rst_ni` goes low, every level bit is one, no pulse timer is running, `rst_line_o` is all zero and `rdata_o` is zero.
- R2: Line N belongs to register k = N / 32 at bit N % 32. Pulse register k is at byte address 4·k. Level register k is at byte address 0x7C + 4·k. Addresses are word aligned, so bits [1:0] must be zero.
- R3: Suppose a write to pulse register k has bit b set and is sampled at edge E. Then `rst_line_o[32k+b]` is high for exactly PULSE_CYC (default 4) cycles, starting after edge E+1. Bits written as zero do not touch their lines.
- R4: Writing a pulse bit again while its timer runs reloads the full count. A second write sampled d cycles after the first therefore gives d + PULSE_CYC high cycles in total.
- R5: Writing level register k stores the whole word. From edge E+1 onwards, a zero bit holds its line high (in reset) and a one bit releases it.
- R6: A read of level register k sampled at edge E returns that register's current value on `rdata_o` after edge E.
- R7: Reads of pulse registers return zero.
- R8: `rst_line_o[N]` is registered. It equals (pulse timer N running) OR (level bit N is zero), with both values taken before the previous edge.
- R9: A write to an address that hits neither bank changes no line and no register. This includes unaligned addresses. A read of such an address returns zero.
- R10: In any cycle after an edge with `rd_en_i` low, `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 8 | Byte address of the access |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_en_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, valid one cycle after the read strobe |
| rst_line_o | output | 256 | Reset lines, 1 = held in reset |

## Verification
The assertions assume that the bus inputs are stable around each rising edge and free of X. The read-back property also assumes that no write shares the read's cycle. The bench drives all inputs on the falling edge and issues at most one access per cycle, which keeps within both assumptions. Random traffic mixes sparse pulse writes, level writes that are mostly ones with a few zeros, reads of both banks, and random addresses that are often unmapped or unaligned. Directed sequences add the pulse-restart and the level read-modify-write cases.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_PULSE = 2'd1,
    ACC_LEVEL = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/rlc_decode.sv
module rlc_decode
  import rlc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_BANKS  = 8,
  parameter int LEVEL_BASE = 'h7C,
  localparam int IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output acc_kind_e         kind_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam logic [ADDR_W-1:0] PULSE_END = ADDR_W'(4 * NUM_BANKS);
  localparam logic [ADDR_W-1:0] LVL_BASE  = ADDR_W'(LEVEL_BASE);
  localparam logic [ADDR_W-1:0] LVL_END   = ADDR_W'(LEVEL_BASE + 4 * NUM_BANKS);

  logic [ADDR_W-1:0] lvl_off;
  assign lvl_off = addr_i - LVL_BASE;

  always_comb begin
    kind_o = ACC_NONE;
    idx_o  = '0;
    if (addr_i[1:0] == 2'b00) begin
      if (addr_i < PULSE_END) begin
        kind_o = ACC_PULSE;
        idx_o  = addr_i[IDX_W+1:2];
      end else if (addr_i >= LVL_BASE && addr_i < LVL_END) begin
        kind_o = ACC_LEVEL;
        idx_o  = lvl_off[IDX_W+1:2];
      end
    end
  end
endmodule

// File: rtl/rlc_pulse_bank.sv
module rlc_pulse_bank #(
  parameter int LINES     = 256,
  parameter int PULSE_CYC = 4,
  localparam int CNT_W    = $clog2(PULSE_CYC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] fire_i,
  output logic [LINES-1:0] active_o
);
  for (genvar n = 0; n < LINES; n++) begin : g_line
    logic [CNT_W-1:0] cnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)              cnt_q <= '0;
      else if (fire_i[n])       cnt_q <= CNT_W'(PULSE_CYC);  // restart on re-fire
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end
    assign active_o[n] = (cnt_q != '0);
  end
endmodule

// File: rtl/rlc_level_bank.sv
module rlc_level_bank #(
  parameter int NUM_BANKS = 8,
  parameter int BANK_W    = 32,
  localparam int IDX_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        wr_i,
  input  logic [IDX_W-1:0]            idx_i,
  input  logic [BANK_W-1:0]           wdata_i,
  output logic [BANK_W-1:0]           rd_word_o,
  output logic [NUM_BANKS*BANK_W-1:0] level_o
);
  logic [BANK_W-1:0] lvl_q [NUM_BANKS];

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             lvl_q[k] <= '1;
      else if (wr_i && idx_i == IDX_W'(k))     lvl_q[k] <= wdata_i;
    end
    assign level_o[k*BANK_W +: BANK_W] = lvl_q[k];
  end

  assign rd_word_o = lvl_q[idx_i];
endmodule

// File: rtl/rst_line_ctrl.sv
module rst_line_ctrl
  import rlc_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int NUM_BANKS  = 8,
  parameter int LEVEL_BASE = 'h7C,
  parameter int PULSE_CYC  = 4,
  localparam int LINES     = NUM_BANKS * DATA_W,
  localparam int IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LINES-1:0]  rst_line_o
);
  acc_kind_e         kind;
  logic [IDX_W-1:0]  idx;
  logic [LINES-1:0]  fire;
  logic [LINES-1:0]  pulse_active;
  logic [LINES-1:0]  level;
  logic [DATA_W-1:0] lvl_word;
  logic [DATA_W-1:0] rdata_q;
  logic [LINES-1:0]  line_q;

  rlc_decode #(
    .ADDR_W    (ADDR_W),
    .NUM_BANKS (NUM_BANKS),
    .LEVEL_BASE(LEVEL_BASE)
  ) i_decode (
    .addr_i(addr_i),
    .kind_o(kind),
    .idx_o (idx)
  );

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_fire
    assign fire[k*DATA_W +: DATA_W] =
      (wr_en_i && kind == ACC_PULSE && idx == IDX_W'(k)) ? wdata_i : '0;
  end

  rlc_pulse_bank #(
    .LINES    (LINES),
    .PULSE_CYC(PULSE_CYC)
  ) i_pulse (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .active_o(pulse_active)
  );

  rlc_level_bank #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (DATA_W)
  ) i_level (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (wr_en_i && kind == ACC_LEVEL),
    .idx_i    (idx),
    .wdata_i  (wdata_i),
    .rd_word_o(lvl_word),
    .level_o  (level)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      line_q  <= '0;
    end else begin
      rdata_q <= (rd_en_i && kind == ACC_LEVEL) ? lvl_word : '0;
      line_q  <= pulse_active | ~level;  // level bank is active low
    end
  end

  assign rdata_o    = rdata_q;
  assign rst_line_o = line_q;
endmodule

// File: rtl/rlc_checks.sv
module rlc_checks #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int NUM_BANKS  = 8,
  parameter int LEVEL_BASE = 'h7C,
  localparam int LINES     = NUM_BANKS * DATA_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wr_en_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic [LINES-1:0]  rst_line_o
);
  localparam logic [ADDR_W-1:0] PULSE_END = ADDR_W'(4 * NUM_BANKS);
  localparam logic [ADDR_W-1:0] LVL_BASE  = ADDR_W'(LEVEL_BASE);
  localparam logic [ADDR_W-1:0] LVL_END   = ADDR_W'(LEVEL_BASE + 4 * NUM_BANKS);

  logic lvl_hit;
  assign lvl_hit = (addr_i[1:0] == 2'b00) && addr_i >= LVL_BASE && addr_i < LVL_END;

  a_r10_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> rdata_o == '0);

  a_r7_pulse_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i < PULSE_END) |=> rdata_o == '0);

  a_r9_unmapped_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !lvl_hit) |=> rdata_o == '0);

  a_r6_level_readback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == LVL_BASE) ##1 (rd_en_i && !wr_en_i && addr_i == LVL_BASE)
    |=> rdata_o == $past(wdata_i, 2));

  for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
    a_r3_pulse_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == ADDR_W'(4 * k)) |=> ##1
      ((rst_line_o[k*DATA_W +: DATA_W] & $past(wdata_i, 2)) == $past(wdata_i, 2)));

    a_r5_level_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_i == ADDR_W'(LEVEL_BASE + 4 * k)) |=> ##1
      ((rst_line_o[k*DATA_W +: DATA_W] | $past(wdata_i, 2)) == '1));
  end
endmodule

bind rst_line_ctrl rlc_checks #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .NUM_BANKS (NUM_BANKS),
  .LEVEL_BASE(LEVEL_BASE)
) i_checks (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .wr_en_i   (wr_en_i),
  .wdata_i   (wdata_i),
  .rd_en_i   (rd_en_i),
  .rdata_o   (rdata_o),
  .rst_line_o(rst_line_o)
);

// File: tb/test_rst_line_ctrl.sv
`timescale 1ns/1ps
module test_rst_line_ctrl;
  localparam int NB    = 8;
  localparam int BW    = 32;
  localparam int LINES = NB * BW;
  localparam int PCYC  = 4;
  localparam int LBASE = 'h7C;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic [7:0]       addr_i = '0;
  logic             wr_en_i = 1'b0;
  logic [31:0]      wdata_i = '0;
  logic             rd_en_i = 1'b0;
  logic [31:0]      rdata_o;
  logic [LINES-1:0] rst_line_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;

  rst_line_ctrl i_rst_line_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .wr_en_i(wr_en_i),
    .wdata_i(wdata_i), .rd_en_i(rd_en_i), .rdata_o(rdata_o), .rst_line_o(rst_line_o)
  );

  always #2.5 clk_i = ~clk_i;

  // ---------------- reference model from the requirements ----------------
  logic [31:0]      m_level [NB];
  int               m_cnt   [LINES];
  logic [LINES-1:0] m_out;
  logic [31:0]      m_rdata;

  function automatic bit is_pulse(logic [7:0] a);
    return a[1:0] == 2'b00 && int'(a) < 4 * NB;
  endfunction
  function automatic bit is_level(logic [7:0] a);
    return a[1:0] == 2'b00 && int'(a) >= LBASE && int'(a) < LBASE + 4 * NB;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NB; k++) m_level[k] = '1;
      for (int n = 0; n < LINES; n++) m_cnt[n] = 0;
      m_out = '0;
      m_rdata = '0;
    end else begin
      logic [LINES-1:0] nxt;
      for (int n = 0; n < LINES; n++)
        nxt[n] = (m_cnt[n] != 0) || !m_level[n / BW][n % BW];
      m_rdata = '0;
      if (rd_en_i && is_level(addr_i)) m_rdata = m_level[(int'(addr_i) - LBASE) / 4];
      for (int n = 0; n < LINES; n++) if (m_cnt[n] > 0) m_cnt[n]--;
      if (wr_en_i) begin
        if (is_pulse(addr_i)) begin
          for (int b = 0; b < BW; b++)
            if (wdata_i[b]) m_cnt[(int'(addr_i) / 4) * BW + b] = PCYC;
        end else if (is_level(addr_i)) begin
          m_level[(int'(addr_i) - LBASE) / 4] = wdata_i;
        end
      end
      m_out = nxt;
    end
  end

  // ---------------- checking ----------------
  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model (R8 output, R6/R7/R9/R10 read data)
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      cycles++;
      checks++;
      if (rst_line_o !== m_out) begin
        failures++;
        $display("FAIL R8 rst_line_o actual=%0h expected=%0h", rst_line_o, m_out);
      end
      check("R6_R10 rdata_o vs model", 64'(rdata_o), 64'(m_rdata));
    end
  end

  task automatic do_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0; addr_i = '0; wdata_i = '0;
  endtask

  task automatic do_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk_i);
    d = rdata_o;
    rd_en_i = 1'b0; addr_i = '0;
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int hi;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk_i);
    // R1 reset state
    check("R1 rst_line_o zero in reset", 64'(rst_line_o == '0), 64'd1);
    check("R1 rdata_o zero in reset", 64'(rdata_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    do_read(8'(LBASE + 4 * 3), rd);
    check("R1 level reads one after reset", 64'(rd), 64'hFFFF_FFFF);

    // R3 single pulse on line 37 (bank 1 bit 5), R2 mapping
    do_write(8'h04, 32'h0000_0020);
    hi = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk_i);
      if (rst_line_o[37]) hi++;
      if (i == 0) check("R2 neighbours untouched", 64'({rst_line_o[36], rst_line_o[38], rst_line_o[5]}), 64'd0);
    end
    check("R3 pulse width", 64'(hi), 64'(PCYC));

    // R4 restart two cycles after first write
    do_write(8'h04, 32'h0000_0020);
    hi = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk_i);
      if (rst_line_o[37]) hi++;
      if (i == 0) begin addr_i = 8'h04; wdata_i = 32'h20; wr_en_i = 1'b1; end
      if (i == 1) begin wr_en_i = 1'b0; addr_i = '0; wdata_i = '0; end
    end
    check("R4 restart extends pulse", 64'(hi), 64'(PCYC + 2));

    // R7 pulse register reads zero
    do_read(8'h04, rd);
    check("R7 pulse register read", 64'(rd), 64'd0);

    // R5/R6 level on line 200 (bank 6 bit 8) via read-modify-write
    do_read(8'(LBASE + 4 * 6), rd);
    do_write(8'(LBASE + 4 * 6), rd & ~32'h100);
    @(negedge clk_i);
    check("R5 cleared level holds line", 64'(rst_line_o[200]), 64'd1);
    check("R5 other lines released", 64'(rst_line_o[201]), 64'd0);
    do_read(8'(LBASE + 4 * 6), rd);
    check("R6 level readback", 64'(rd), 64'hFFFF_FEFF);
    do_write(8'(LBASE + 4 * 6), 32'hFFFF_FFFF);
    @(negedge clk_i);
    check("R5 set level releases line", 64'(rst_line_o[200]), 64'd0);

    // R9 unmapped and unaligned accesses
    do_write(8'h40, 32'h0);
    do_write(8'(LBASE + 1), 32'h0);
    do_write(8'h05, 32'hFFFF_FFFF);
    repeat (2) @(negedge clk_i);
    check("R9 ignored writes leave lines released", 64'(rst_line_o == '0), 64'd1);
    do_read(8'h40, rd);
    check("R9 unmapped read", 64'(rd), 64'd0);
    do_read(8'(LBASE + 4 * 0), rd);
    check("R9 level bank 0 unchanged", 64'(rd), 64'hFFFF_FFFF);
    @(negedge clk_i);
    check("R10 idle rdata zero", 64'(rdata_o), 64'd0);

    // random traffic, checked per cycle by the model
    for (int i = 0; i < 4000; i++) begin
      int op;
      logic [7:0] a;
      op = int'($urandom % 8);
      if ($urandom % 10 < 7)
        a = ($urandom % 2 == 0) ? 8'(4 * ($urandom % NB)) : 8'(LBASE + 4 * ($urandom % NB));
      else
        a = 8'($urandom);
      @(negedge clk_i);
      wr_en_i = 1'b0; rd_en_i = 1'b0;
      addr_i = a;
      case (op)
        0, 1: begin wr_en_i = 1'b1; wdata_i = $urandom & $urandom & $urandom; end
        2:    begin wr_en_i = 1'b1; wdata_i = ~($urandom & $urandom & $urandom); end
        3, 4: rd_en_i = 1'b1;
        default: ;
      endcase
    end
    @(negedge clk_i);
    wr_en_i = 1'b0; rd_en_i = 1'b0;
    repeat (PCYC + 3) @(negedge clk_i);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule